// File: doc/BRIEF.md
# Sign-Magnitude PWM Generator with Fractional Rate Reference

This block drives several PWM channels from one shared time base. A 16-bit phase accumulator adds a programmable rate word on every clock. Each carry out of the accumulator advances a 10-bit frame counter, so one PWM frame lasts 1024 × 65536 / rate clocks. Each channel holds a 16-bit command word and a small control word. It compares the frame counter against a 10-bit duty code taken from the command and produces a PWM output, a direction output with its output enable, and an enable output.

The command word can be read as two's complement, with the magnitude going to the PWM and the sign going to the direction pin. It can also be read as unsigned, in which case the direction pin becomes an input that software reads back. An interlaced mode compares against the bit-reversed counter. This spreads the on-time evenly across the frame, so a simple low-pass filter turns the output into an analog level. A new command takes effect only at the frame boundary. A global enable gates every channel, and a global clear strobe zeroes all commands at once.

Top module: `smpwm_top`

## Requirements
- R1: While and after reset, every pwm_o, ena_o, dir_o and dir_oe bit is 0, and rd_ctl reads 0.
- R2: The frame counter advances by exactly one on each clock where the 16-bit sum acc + rate carries out. A rise-to-rise PWM period is 1024 × 65536 / rate clocks (4096 clocks at rate 16384). With rate 0 the counter and every output freeze.
- R3: In normal mode (control bit 1 = 0), pwm_o is high while the frame counter is below the channel's 10-bit duty code, so a frame holds exactly duty-code counter steps of high.
- R4: In signed mode (control bit 2 = 0) the duty code is min(|value| >> 5, 1023), with -32768 giving 1023. dir_o equals bit 15 of the value, and dir_oe is 1 while the channel output is enabled.
- R5: In unsigned mode (control bit 2 = 1) the duty code is value[15:6]. dir_oe is 0, and rd_ctl bit 4 shows the dir_i pin.
- R6: In interlaced mode (control bit 1 = 1), pwm_o is high while the bit-reversed frame counter is below the duty code. The high count per frame is the same as in normal mode, but a duty code of 512 gives 512 separate high pulses per frame.
- R7: A written value is transferred into the active duty code and direction only when the counter wraps from 1023 to 0. A frame in progress keeps its duty.
- R8: ena_o of a channel equals glob_en AND its control bit 0. pwm_o is forced low whenever ena_o is low.
- R9: A one-cycle clr_all zeroes every channel's stored and active value, so every pwm_o is low from the next clock on.
- R10: rd_ctl returns, for channel rd_sel: bit 0 enable, bit 1 interlace, bit 2 unsigned, bit 3 the live pwm_o, bit 4 the direction (dir_i in unsigned mode, dir_o in signed mode).
- R11: A write addressed by wsel changes only that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate | input | 16 | Phase increment added each clock |
| glob_en | input | 1 | Global output enable for all channels |
| clr_all | input | 1 | Strobe: zero all channel values |
| val_we | input | 1 | Write wdata into value of channel wsel |
| ctl_we | input | 1 | Write wdata[2:0] into control of channel wsel |
| wsel | input | 2 | Channel selected for writes |
| wdata | input | 16 | Write data |
| rd_sel | input | 2 | Channel selected for control readback |
| rd_ctl | output | 5 | Control/status readback of channel rd_sel |
| dir_i | input | 4 | Direction pins sampled in unsigned mode |
| pwm_o | output | 4 | PWM outputs |
| dir_o | output | 4 | Direction (sign) outputs |
| dir_oe | output | 4 | Direction output enables |
| ena_o | output | 4 | Channel enable outputs |

## Verification
The hardest situation to reach is a write that lands in the middle of a frame. The ports expose no counter, so the bench locks onto the frame boundary by watching for the rising edge of pwm_o, which happens exactly at wrap whenever the duty code is nonzero. It then writes a new value a known number of clocks later and samples pwm_o at a point where the old and new duty codes give different levels. Duty is measured by counting high samples over a whole frame window, which works at any alignment once the value is stable. Interlacing is told apart from normal mode by counting rising edges in that same window.

// File: rtl/smpwm_pkg.sv
package smpwm_pkg;
    localparam int VAL_W = 16;
    localparam int RES_W = 10;
    localparam int ACC_W = 16;
    localparam int CTL_W = 5;

    typedef struct packed {
        logic uns;
        logic ilv;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic [RES_W-1:0] code;
        logic             sgn;
    } duty_t;

    function automatic logic [RES_W-1:0] bitrev(input logic [RES_W-1:0] x);
        logic [RES_W-1:0] r;
        for (int i = 0; i < RES_W; i++) r[i] = x[RES_W-1-i];
        return r;
    endfunction

    function automatic duty_t to_duty(input logic [VAL_W-1:0] v, input logic uns);
        duty_t d;
        logic [VAL_W-1:0] mag;
        if (uns) begin
            d.code = v[VAL_W-1 -: RES_W];
            d.sgn  = 1'b0;
        end else begin
            mag   = v[VAL_W-1] ? (~v + 1'b1) : v;
            d.sgn = v[VAL_W-1];
            if (mag[VAL_W-1]) d.code = '1;
            else              d.code = mag[VAL_W-2 -: RES_W];
        end
        return d;
    endfunction
endpackage

// File: rtl/smpwm_nco.sv
module smpwm_nco
    import smpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] rate,
    output logic [RES_W-1:0] cnt,
    output logic             wrap
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   sum;
    logic             tick;

    always_comb begin
        sum  = {1'b0, acc} + {1'b0, rate};
        tick = sum[ACC_W];
        wrap = tick && (cnt == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            cnt <= '0;
        end else begin
            acc <= sum[ACC_W-1:0];
            if (tick) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/smpwm_chan.sv
module smpwm_chan
    import smpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  logic [RES_W-1:0] cnt,
    input  logic             clr,
    input  logic             glob_en,
    input  logic             val_we,
    input  logic             ctl_we,
    input  logic [VAL_W-1:0] wdata,
    input  logic             dir_in,
    output logic             pwm,
    output logic             ena,
    output logic             dir,
    output logic             dir_oe,
    output logic [CTL_W-1:0] rd,
    output logic [RES_W-1:0] act_code
);
    ctl_t             ctl;
    logic [VAL_W-1:0] val;
    duty_t            nxt;
    logic             act_sgn;
    logic [RES_W-1:0] cmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            val      <= '0;
            act_code <= '0;
            act_sgn  <= 1'b0;
        end else begin
            if (ctl_we) ctl <= ctl_t'(wdata[2:0]);
            if (clr) begin
                val      <= '0;
                act_code <= '0;
                act_sgn  <= 1'b0;
            end else begin
                if (val_we) val <= wdata;
                if (wrap) begin
                    act_code <= nxt.code;
                    act_sgn  <= nxt.sgn;
                end
            end
        end
    end

    always_comb begin
        nxt    = to_duty(val, ctl.uns);
        cmp    = ctl.ilv ? bitrev(cnt) : cnt;
        ena    = glob_en & ctl.en;
        pwm    = ena & (cmp < act_code);
        dir    = act_sgn & ~ctl.uns;
        dir_oe = ena & ~ctl.uns;
        rd     = {(ctl.uns ? dir_in : dir), pwm, ctl.uns, ctl.ilv, ctl.en};
    end
endmodule

// File: rtl/smpwm_top.sv
module smpwm_top
    import smpwm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] rate,
    input  logic             glob_en,
    input  logic             clr_all,
    input  logic             val_we,
    input  logic             ctl_we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [VAL_W-1:0] wdata,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [CTL_W-1:0] rd_ctl,
    input  logic [NCH-1:0]   dir_i,
    output logic [NCH-1:0]   pwm_o,
    output logic [NCH-1:0]   dir_o,
    output logic [NCH-1:0]   dir_oe,
    output logic [NCH-1:0]   ena_o
);
    logic [RES_W-1:0] cnt_q;
    logic             wrap;
    logic [CTL_W-1:0] rd_w   [NCH];
    logic [RES_W-1:0] code_w [NCH];

    smpwm_nco u_nco (
        .clk  (clk),
        .rst  (rst),
        .rate (rate),
        .cnt  (cnt_q),
        .wrap (wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        smpwm_chan u_ch (
            .clk      (clk),
            .rst      (rst),
            .wrap     (wrap),
            .cnt      (cnt_q),
            .clr      (clr_all),
            .glob_en  (glob_en),
            .val_we   (val_we && (wsel == SEL_W'(g))),
            .ctl_we   (ctl_we && (wsel == SEL_W'(g))),
            .wdata    (wdata),
            .dir_in   (dir_i[g]),
            .pwm      (pwm_o[g]),
            .ena      (ena_o[g]),
            .dir      (dir_o[g]),
            .dir_oe   (dir_oe[g]),
            .rd       (rd_w[g]),
            .act_code (code_w[g])
        );
    end

    assign rd_ctl = rd_w[rd_sel];
endmodule

// File: rtl/smpwm_chk.sv
module smpwm_chk
    import smpwm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [ACC_W-1:0] rate,
    input logic             glob_en,
    input logic             clr_all,
    input logic [RES_W-1:0] cnt,
    input logic [RES_W-1:0] code0,
    input logic [NCH-1:0]   pwm_o,
    input logic [NCH-1:0]   ena_o
);
    a_r8_global_gate: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> (pwm_o == '0 && ena_o == '0));

    a_r8_pwm_needs_ena: assert property (@(posedge clk) disable iff (rst)
        (pwm_o & ~ena_o) == '0);

    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (pwm_o == '0));

    a_r2_freeze: assert property (@(posedge clk) disable iff (rst)
        (rate == '0) |=> $stable(cnt));

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

    a_r7_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (code0 != $past(code0)) |-> ($past(cnt) == '1 || $past(clr_all)));
endmodule

bind smpwm_top smpwm_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rate    (rate),
    .glob_en (glob_en),
    .clr_all (clr_all),
    .cnt     (cnt_q),
    .code0   (code_w[0]),
    .pwm_o   (pwm_o),
    .ena_o   (ena_o)
);

// File: tb/sim_smpwm_top.sv
module sim_smpwm_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rate = 16'd0;
    logic        glob_en = 1'b0;
    logic        clr_all = 1'b0;
    logic        val_we = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  wsel = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [4:0]  rd_ctl;
    logic [3:0]  dir_i = 4'd0;
    logic [3:0]  pwm_o, dir_o, dir_oe, ena_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    smpwm_top u0 (
        .clk(clk), .rst(rst), .rate(rate), .glob_en(glob_en), .clr_all(clr_all),
        .val_we(val_we), .ctl_we(ctl_we), .wsel(wsel), .wdata(wdata),
        .rd_sel(rd_sel), .rd_ctl(rd_ctl), .dir_i(dir_i),
        .pwm_o(pwm_o), .dir_o(dir_o), .dir_oe(dir_oe), .ena_o(ena_o)
    );

    // {ctl[2:0] (uns,ilv,en), value, expected duty code, expected sign}
    localparam logic [29:0] VEC [11] = '{
        {3'b001, 16'h0000, 10'd0,    1'b0},
        {3'b001, 16'h4000, 10'd512,  1'b0},
        {3'b001, 16'hC000, 10'd512,  1'b1},
        {3'b001, 16'h7FFF, 10'd1023, 1'b0},
        {3'b001, 16'h8000, 10'd1023, 1'b1},
        {3'b001, 16'hFFFF, 10'd0,    1'b1},
        {3'b001, 16'h0020, 10'd1,    1'b0},
        {3'b101, 16'h8000, 10'd512,  1'b0},
        {3'b101, 16'hFFFF, 10'd1023, 1'b0},
        {3'b101, 16'h0040, 10'd1,    1'b0},
        {3'b011, 16'h4000, 10'd512,  1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_val(input int ch, input logic [15:0] v);
        wsel = 2'(ch); wdata = v; val_we = 1'b1;
        @(negedge clk);
        val_we = 1'b0;
    endtask

    task automatic wr_ctl(input int ch, input logic [2:0] c);
        wsel = 2'(ch); wdata = {13'd0, c}; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic count_hi(input int ch, input int n, output int hi, output int rises);
        logic prev;
        hi = 0; rises = 0; prev = pwm_o[ch];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o[ch]) hi++;
            if (pwm_o[ch] && !prev) rises++;
            prev = pwm_o[ch];
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_o[ch];
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pwm_o[ch] && !prev) return;
            prev = pwm_o[ch];
        end
    endtask

    initial begin
        int hi, rs, hi1, rs1, t0, t1, bad;
        logic [2:0]  c;
        logic [15:0] v;
        logic [9:0]  code;
        logic        sg;

        clks(4);
        // R1: reset state
        chk("R1 pwm_o", pwm_o, 0);
        chk("R1 ena_o", ena_o, 0);
        chk("R1 dir_oe", dir_oe, 0);
        chk("R1 rd_ctl", rd_ctl, 0);
        rst = 1'b0;
        clks(2);
        chk("R1 dir_o after reset", dir_o, 0);

        rate = 16'd32768;   // one counter step every 2 clocks, frame 2048 clocks
        glob_en = 1'b1;

        // Table walk: R3 duty, R4 signed, R5 unsigned, R6 interlace
        foreach (VEC[k]) begin
            {c, v, code, sg} = VEC[k];
            wr_ctl(0, c);
            wr_val(0, v);
            clks(4096);
            count_hi(0, 2048, hi, rs);
            if (c[1])      chk($sformatf("R6 vec%0d high count", k), hi, 2 * code);
            else if (c[2]) chk($sformatf("R5 vec%0d high count", k), hi, 2 * code);
            else           chk($sformatf("R4 R3 vec%0d high count", k), hi, 2 * code);
            if (c[2]) begin
                chk($sformatf("R5 vec%0d dir_oe", k), dir_oe[0], 0);
            end else begin
                chk($sformatf("R4 vec%0d dir_o", k), dir_o[0], sg);
                chk($sformatf("R4 vec%0d dir_oe", k), dir_oe[0], 1);
            end
        end

        // R6: interlaced 512 gives 512 pulses; normal gives one
        wr_ctl(0, 3'b011); wr_val(0, 16'h4000); clks(4096);
        count_hi(0, 2048, hi, rs);
        chk("R6 interlace rises", rs, 512);
        wr_ctl(0, 3'b001); clks(2048);
        count_hi(0, 2048, hi, rs);
        chk("R3 normal rises", rs, 1);
        chk("R3 normal high", hi, 1024);

        // R7: mid-frame write keeps current frame duty
        wait_rise(0);
        clks(300);
        wr_val(0, 16'h0000);
        clks(600);
        chk("R7 old duty kept mid-frame", pwm_o[0], 1);
        clks(2300);
        count_hi(0, 2048, hi, rs);
        chk("R7 new duty after wrap", hi, 0);

        // R10: readback of control fields and live pwm
        wr_ctl(0, 3'b011); wr_val(0, 16'h4000); clks(4096);
        rd_sel = 2'd0;
        @(negedge clk);
        chk("R10 ctl fields", rd_ctl[2:0], 3'b011);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rd_ctl[3] != pwm_o[0]) bad++;
        end
        chk("R10 live pwm readback mismatches", bad, 0);
        chk("R10 signed dir readback", rd_ctl[4], dir_o[0]);

        // R5: unsigned mode reads dir_i
        wr_ctl(0, 3'b101);
        dir_i = 4'b0001; @(negedge clk);
        chk("R5 dir_i readback high", rd_ctl[4], 1);
        dir_i = 4'b0000; @(negedge clk);
        chk("R5 dir_i readback low", rd_ctl[4], 0);

        // R8: global enable and channel enable gating
        wr_ctl(0, 3'b001); wr_val(0, 16'h4000); clks(4096);
        glob_en = 1'b0;
        count_hi(0, 2048, hi, rs);
        chk("R8 glob_en off pwm", hi, 0);
        chk("R8 glob_en off ena", ena_o[0], 0);
        glob_en = 1'b1; @(negedge clk);
        chk("R8 ena on", ena_o[0], 1);
        wr_ctl(0, 3'b000);
        chk("R8 ctl en off ena", ena_o[0], 0);
        count_hi(0, 2048, hi, rs);
        chk("R8 ctl en off pwm", hi, 0);

        // R11: independent channels
        wr_ctl(0, 3'b001); wr_ctl(1, 3'b001);
        wr_val(0, 16'h2000); wr_val(1, 16'hC000);
        clks(4096);
        count_hi(0, 2048, hi, rs);
        count_hi(1, 2048, hi1, rs1);
        chk("R11 ch0 high", hi, 512);
        chk("R11 ch1 high", hi1, 1024);
        chk("R11 ch1 dir", dir_o[1], 1);
        chk("R11 ch0 dir", dir_o[0], 0);

        // R9: clear-all strobe
        wait_rise(0);
        clks(4);
        clr_all = 1'b1; @(negedge clk); clr_all = 1'b0;
        chk("R9 pwm low next cycle", pwm_o, 0);
        count_hi(1, 4096, hi1, rs1);
        chk("R9 ch1 stays low", hi1, 0);
        chk("R9 ch1 dir cleared", dir_o[1], 0);

        // R2: frame period at rate 16384 is 4096 clocks
        wr_val(0, 16'h4000);
        rate = 16'd16384;
        clks(9000);
        wait_rise(0); t0 = $time;
        wait_rise(0); t1 = $time;
        chk("R2 period clocks", (t1 - t0) / 4, 4096);

        // R2: rate 0 freezes outputs
        wait_rise(0);
        clks(100);
        rate = 16'd0;
        @(negedge clk);
        count_hi(0, 3000, hi, rs);
        chk("R2 frozen high count", hi, 3000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(190000 * 4);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule